// File: doc/BRIEF.md
# Timer Event Flags with Interlocked Clear

This block holds the five event flags of a 16-bit free-running timer that has two capture channels and two compare channels. Each flag is set by a one-cycle pulse from the timer datapath: a capture strobe, a compare-match pulse, or the counter wrap from FFFFh to 0000h. The counter, the capture latches and the comparators are outside this block. Software sees the flags as one read-only status byte on a simple register bus.

A flag clears only through a two-step handshake. Software first reads the status byte, which arms a clear for every flag that was 1 at that moment. It then reads or writes the low byte of the register tied to that flag. An armed clear is used once and then dropped. A set pulse in the same cycle as the clear wins. An access to the alternate counter register never clears the overflow flag.

A four-bit routing byte picks, for each of the overflow, compare, capture and global interrupt requests, either the timer source or an external interrupt line.

Top module: `tmr_evt_flags`

## Requirements
- R1: After reset the status byte reads 00h, the routing byte reads 00h, and each interrupt output follows its external line.
- R2: The status byte at address FEh has capture-1 in bit 7, compare-1 in bit 6, overflow in bit 5, capture-2 in bit 4 and compare-2 in bit 3. Bits 2..0 always read 0. A bus read of FEh returns the flags as they stood before that cycle's clock edge.
- R3: A capture strobe, compare pulse or wrap pulse sampled at a clock edge makes its flag read 1 after that edge.
- R4: A flag clears only when a status read is followed by a read or write of its low-byte address: capture-1 01h, compare-1 03h, main counter 05h, capture-2 07h, compare-2 09h. Without a prior status read, such an access has no effect, and an access clears only its own flag.
- R5: A clear is armed only for flags that were 1 when the status read happened. A flag that sets after the read stays set through the following low-byte access.
- R6: When a set pulse and a clearing access happen in the same cycle, the flag stays 1.
- R7: An armed clear is used up by one low-byte access. Without a new status read, a second access does not clear the flag. A bus write to the status address does not arm anything.
- R8: Reads or writes of the alternate counter register (0Bh), of the high-byte addresses, or of any other address never clear a flag.
- R9: Writes to the status address leave the status byte unchanged.
- R10: The routing byte at address FFh stores bits 3..0 on a write. Bits 7..4 read 0.
- R11: In the routing byte and in irq_o, bit 3 is overflow, bit 2 is compare, bit 1 is capture and bit 0 is global. A 1 selects the timer source and a 0 selects the external line. The compare source is the OR of both compare flags, the capture source is the OR of both capture flags, and the global source is the OR of all five flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_evt_i | input | 2 | Capture strobes; bit 0 channel 1, bit 1 channel 2 |
| cmp_evt_i | input | 2 | Compare-match pulses; bit 0 channel 1, bit 1 channel 2 |
| wrap_evt_i | input | 1 | Counter wrap pulse |
| bus_rd_i | input | 1 | Register read strobe |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the status and routing addresses, 0 elsewhere |
| status_o | output | 8 | Live status byte |
| ext_irq_i | input | 4 | External interrupt lines, same bit order as irq_o |
| irq_o | output | 4 | Routed requests: 3 overflow, 2 compare, 1 capture, 0 global |

## Verification
The handshake is tried with several access orders. A low-byte access with no prior read separates a design that needs arming from one that does not. A flag that sets between the read and the access separates arming by snapshot from arming by flag name. A second access after one clear separates one-shot arms from sticky ones. Accesses to the alternate counter, to a high byte, and a status write expose loose address decoding. A set and a clear in the same cycle shows the priority. The routing checks mix timer and external selections, with one and then two flags set, so that each OR term and each select bit is seen on its own.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;
  localparam int NFLAG  = 5;
  localparam int DATA_W = 8;
  localparam int NIRQ   = 4;
  localparam int PAD_W  = DATA_W - NFLAG;

  // flag indices; status bit = index + PAD_W (order decoded by software)
  localparam int FL_CMP2 = 0;
  localparam int FL_CAP2 = 1;
  localparam int FL_OVF  = 2;
  localparam int FL_CMP1 = 3;
  localparam int FL_CAP1 = 4;

  // interrupt routing bits
  localparam int IR_GLB = 0;
  localparam int IR_CAP = 1;
  localparam int IR_CMP = 2;
  localparam int IR_OVF = 3;

  localparam logic [DATA_W-1:0] CTRL_MASK = DATA_W'((1 << NIRQ) - 1);

  function automatic logic next_flag(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction

  function automatic logic [DATA_W-1:0] pack_status(logic [NFLAG-1:0] f);
    return {f, {PAD_W{1'b0}}};
  endfunction

  function automatic logic [NIRQ-1:0] timer_src(logic [NFLAG-1:0] f);
    logic [NIRQ-1:0] s;
    s[IR_OVF] = f[FL_OVF];
    s[IR_CMP] = f[FL_CMP1] | f[FL_CMP2];
    s[IR_CAP] = f[FL_CAP1] | f[FL_CAP2];
    s[IR_GLB] = |f;
    return s;
  endfunction
endpackage

// File: rtl/tmr_acc_decode.sv
module tmr_acc_decode
  import tmr_evt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] A_STAT = 8'hFE,
  parameter logic [ADDR_W-1:0] A_CTRL = 8'hFF,
  parameter logic [NFLAG*ADDR_W-1:0] LO_ADDRS = '0
) (
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              rd_stat_o,
  output logic              wr_ctrl_o,
  output logic [NFLAG-1:0]  acc_o
);
  assign rd_stat_o = rd_i && (addr_i == A_STAT);
  assign wr_ctrl_o = wr_i && (addr_i == A_CTRL);

  for (genvar i = 0; i < NFLAG; i++) begin : g_lo
    assign acc_o[i] = (rd_i || wr_i) && (addr_i == LO_ADDRS[i*ADDR_W +: ADDR_W]);
  end
endmodule

// File: rtl/tmr_flag_cell.sv
module tmr_flag_cell
  import tmr_evt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic rd_stat_i,
  input  logic acc_i,
  output logic flag_o,
  output logic arm_o
);
  logic flag_q, arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= next_flag(flag_q, set_i, acc_i & arm_q);
      if (rd_stat_i)  arm_q <= flag_q;
      else if (acc_i) arm_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign arm_o  = arm_q;
endmodule

// File: rtl/tmr_irq_route.sv
module tmr_irq_route
  import tmr_evt_pkg::*;
(
  input  logic [NIRQ-1:0]  sel_i,
  input  logic [NIRQ-1:0]  ext_i,
  input  logic [NFLAG-1:0] flags_i,
  output logic [NIRQ-1:0]  irq_o
);
  logic [NIRQ-1:0] src;
  assign src = timer_src(flags_i);

  for (genvar i = 0; i < NIRQ; i++) begin : g_mux
    assign irq_o[i] = sel_i[i] ? src[i] : ext_i[i];
  end
endmodule

// File: rtl/tmr_evt_flags.sv
module tmr_evt_flags
  import tmr_evt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] A_STAT    = 8'hFE,
  parameter logic [ADDR_W-1:0] A_CTRL    = 8'hFF,
  parameter logic [ADDR_W-1:0] A_CAP1_LO = 8'h01,
  parameter logic [ADDR_W-1:0] A_CMP1_LO = 8'h03,
  parameter logic [ADDR_W-1:0] A_CNT_LO  = 8'h05,
  parameter logic [ADDR_W-1:0] A_CAP2_LO = 8'h07,
  parameter logic [ADDR_W-1:0] A_CMP2_LO = 8'h09
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cap_evt_i,
  input  logic [1:0]        cmp_evt_i,
  input  logic              wrap_evt_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [DATA_W-1:0] status_o,
  input  logic [NIRQ-1:0]   ext_irq_i,
  output logic [NIRQ-1:0]   irq_o
);
  localparam logic [NFLAG*ADDR_W-1:0] LO_ADDRS =
    {A_CAP1_LO, A_CMP1_LO, A_CNT_LO, A_CAP2_LO, A_CMP2_LO};

  // named internal events, visible to the bound checker
  logic [NFLAG-1:0]  set_vec;
  logic [NFLAG-1:0]  acc_vec;
  logic [NFLAG-1:0]  arm_vec;
  logic [NFLAG-1:0]  flag_vec;
  logic              rd_stat;
  logic              wr_ctrl;
  logic [DATA_W-1:0] ctrl_q;

  assign set_vec[FL_CAP1] = cap_evt_i[0];
  assign set_vec[FL_CMP1] = cmp_evt_i[0];
  assign set_vec[FL_OVF]  = wrap_evt_i;
  assign set_vec[FL_CAP2] = cap_evt_i[1];
  assign set_vec[FL_CMP2] = cmp_evt_i[1];

  tmr_acc_decode #(
    .ADDR_W(ADDR_W), .A_STAT(A_STAT), .A_CTRL(A_CTRL), .LO_ADDRS(LO_ADDRS)
  ) u_dec (
    .rd_i(bus_rd_i), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
    .rd_stat_o(rd_stat), .wr_ctrl_o(wr_ctrl), .acc_o(acc_vec)
  );

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    tmr_flag_cell u_cell (
      .clk(clk), .rst_n(rst_n), .set_i(set_vec[i]), .rd_stat_i(rd_stat),
      .acc_i(acc_vec[i]), .flag_o(flag_vec[i]), .arm_o(arm_vec[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= bus_wdata_i & CTRL_MASK;
  end

  assign status_o = pack_status(flag_vec);

  always_comb begin
    if (bus_addr_i == A_STAT)      bus_rdata_o = status_o;
    else if (bus_addr_i == A_CTRL) bus_rdata_o = ctrl_q;
    else                           bus_rdata_o = '0;
  end

  tmr_irq_route u_route (
    .sel_i(ctrl_q[NIRQ-1:0]), .ext_i(ext_irq_i), .flags_i(flag_vec), .irq_o(irq_o)
  );
endmodule

// File: rtl/tmr_evt_flags_chk.sv
module tmr_evt_flags_chk
  import tmr_evt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [NFLAG-1:0]  set_vec,
  input logic [NFLAG-1:0]  acc_vec,
  input logic [NFLAG-1:0]  arm_vec,
  input logic [NFLAG-1:0]  flag_vec,
  input logic              rd_stat,
  input logic [DATA_W-1:0] status_o,
  input logic [DATA_W-1:0] ctrl_q,
  input logic [NIRQ-1:0]   ext_irq_i,
  input logic [NIRQ-1:0]   irq_o
);
  p_pad_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[PAD_W-1:0] == '0);

  p_set_visible_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((flag_vec & $past(set_vec)) == $past(set_vec)));

  p_clear_needs_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(flag_vec) & ~flag_vec & ~($past(acc_vec) & $past(arm_vec))) == '0));

  p_arm_snapshot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |=> (arm_vec == $past(flag_vec)));

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec & acc_vec & arm_vec) != '0) |=>
      ((flag_vec & $past(set_vec & acc_vec)) == $past(set_vec & acc_vec)));

  p_arm_one_shot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stat && (acc_vec != '0)) |=> ((arm_vec & $past(acc_vec)) == '0));

  p_ctrl_hi_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[DATA_W-1:NIRQ] == '0);

  p_ext_route_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((~ctrl_q[NIRQ-1:0] & (irq_o ^ ext_irq_i)) == '0));

  p_ovf_route_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[IR_OVF] |-> (irq_o[IR_OVF] == status_o[FL_OVF + PAD_W]));
endmodule

bind tmr_evt_flags tmr_evt_flags_chk chk_i (
  .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .acc_vec(acc_vec),
  .arm_vec(arm_vec), .flag_vec(flag_vec), .rd_stat(rd_stat),
  .status_o(status_o), .ctrl_q(ctrl_q), .ext_irq_i(ext_irq_i), .irq_o(irq_o)
);

// File: tb/tmr_evt_flags_tb.sv
`timescale 1ns/1ps
module tmr_evt_flags_tb_top;
  localparam int NROW = 22;
  localparam logic [1:0] IDL = 2'd0, RD = 2'd1, WR = 2'd2;
  localparam logic [7:0] AST = 8'hFE, ACT = 8'hFF, AC1 = 8'h01, AM1 = 8'h03,
                         ACN = 8'h05, AC2 = 8'h07, AM2 = 8'h09, AALT = 8'h0B,
                         AC1H = 8'h00;

  // row: op(2) addr(8) wdata(8) cap(2) cmp(2) wrap(1) exp_status(8)
  localparam logic [30:0] TBL [0:NROW-1] = '{
    {IDL, 8'h00, 8'h00, 2'b01, 2'b00, 1'b0, 8'h80},  // R3 capture-1
    {IDL, 8'h00, 8'h00, 2'b00, 2'b10, 1'b0, 8'h88},  // R3 compare-2
    {IDL, 8'h00, 8'h00, 2'b00, 2'b00, 1'b1, 8'hA8},  // R3 wrap
    {RD,  AC1,   8'h00, 2'b00, 2'b00, 1'b0, 8'hA8},  // R4 no prior read
    {RD,  AST,   8'h00, 2'b00, 2'b00, 1'b0, 8'hA8},  // arm
    {WR,  AALT,  8'h55, 2'b00, 2'b00, 1'b0, 8'hA8},  // R8 alt counter
    {RD,  AC1H,  8'h00, 2'b00, 2'b00, 1'b0, 8'hA8},  // R8 high byte
    {WR,  AC1,   8'h12, 2'b00, 2'b00, 1'b0, 8'h28},  // R4 write clears
    {RD,  ACN,   8'h00, 2'b00, 2'b00, 1'b0, 8'h08},  // R4 counter low
    {IDL, 8'h00, 8'h00, 2'b10, 2'b00, 1'b0, 8'h18},  // capture-2 late
    {RD,  AC2,   8'h00, 2'b00, 2'b00, 1'b0, 8'h18},  // R5 not armed
    {RD,  AM2,   8'h00, 2'b00, 2'b00, 1'b0, 8'h10},  // R4 compare-2
    {IDL, 8'h00, 8'h00, 2'b00, 2'b01, 1'b0, 8'h50},
    {RD,  AST,   8'h00, 2'b00, 2'b00, 1'b0, 8'h50},
    {RD,  AM1,   8'h00, 2'b00, 2'b01, 1'b0, 8'h50},  // R6 set wins
    {WR,  AM1,   8'h00, 2'b00, 2'b00, 1'b0, 8'h50},  // R7 used up
    {WR,  AST,   8'hFF, 2'b00, 2'b00, 1'b0, 8'h50},  // R9 status write
    {RD,  AM1,   8'h00, 2'b00, 2'b00, 1'b0, 8'h50},  // R7 write did not arm
    {RD,  AST,   8'h00, 2'b00, 2'b00, 1'b0, 8'h50},
    {RD,  AC2,   8'h00, 2'b00, 2'b00, 1'b0, 8'h40},
    {RD,  AM1,   8'h00, 2'b00, 2'b00, 1'b0, 8'h00},
    {IDL, 8'h00, 8'h00, 2'b11, 2'b11, 1'b1, 8'hF8}   // R3 all at once
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cap_evt_i = '0, cmp_evt_i = '0;
  logic       wrap_evt_i = 1'b0, bus_rd_i = 1'b0, bus_wr_i = 1'b0;
  logic [7:0] bus_addr_i = '0, bus_wdata_i = '0, bus_rdata_o, status_o;
  logic [3:0] ext_irq_i = '0, irq_o;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tmr_evt_flags dut_i (
    .clk(clk), .rst_n(rst_n), .cap_evt_i(cap_evt_i), .cmp_evt_i(cmp_evt_i),
    .wrap_evt_i(wrap_evt_i), .bus_rd_i(bus_rd_i), .bus_wr_i(bus_wr_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .status_o(status_o), .ext_irq_i(ext_irq_i), .irq_o(irq_o)
  );

  function automatic logic [3:0] want_irq(logic [7:0] st, logic [3:0] sel, logic [3:0] ext);
    logic [3:0] t;
    t = {st[5], st[6] | st[3], st[7] | st[4], |st[7:3]};
    return (t & sel) | (ext & ~sel);
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at a negedge, take one posedge, return at the next negedge idle
  task automatic cycle(logic [1:0] op, logic [7:0] a, logic [7:0] d,
                       logic [1:0] cp, logic [1:0] cm, logic wr);
    bus_rd_i = (op == RD); bus_wr_i = (op == WR); bus_addr_i = a; bus_wdata_i = d;
    cap_evt_i = cp; cmp_evt_i = cm; wrap_evt_i = wr;
    @(posedge clk); @(negedge clk);
    bus_rd_i = 0; bus_wr_i = 0; bus_addr_i = 8'h00; cap_evt_i = 0; cmp_evt_i = 0; wrap_evt_i = 0;
  endtask

  task automatic read_reg(logic [7:0] a, output logic [7:0] v);
    bus_addr_i = a; #1 v = bus_rdata_o; bus_addr_i = 8'h00;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] prev;
    ext_irq_i = 4'b0110;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 status", status_o, 8'h00);
    read_reg(ACT, v); check("R1 routing", v, 8'h00);
    check("R1 irq", {4'h0, irq_o}, {4'h0, ext_irq_i});
    rst_n = 1'b1;
    ext_irq_i = 4'b0000;
    @(negedge clk);

    prev = 8'h00;
    for (int i = 0; i < NROW; i++) begin
      logic [30:0] r;
      r = TBL[i];
      if (r[30:29] == RD && r[28:21] == AST) begin
        bus_addr_i = AST; #1;
        check($sformatf("R2 status read row %0d", i), bus_rdata_o, prev);
        @(negedge clk);
      end
      cycle(r[30:29], r[28:21], r[20:13], r[12:11], r[10:9], r[8]);
      check($sformatf("R2-layout/R3..R9 row %0d", i), status_o, r[7:0]);
      prev = r[7:0];
    end

    // R2 pad bits
    check("R2 low bits", {5'b0, status_o[2:0]}, 8'h00);

    // R10 routing byte
    cycle(WR, ACT, 8'hFF, 2'b00, 2'b00, 1'b0);
    read_reg(ACT, v); check("R10 routing readback", v, 8'h0F);
    // R11 all timer sources, flags F8
    check("R11 timer all", {4'h0, irq_o}, {4'h0, want_irq(8'hF8, 4'hF, 4'h0)});
    cycle(WR, ACT, 8'h00, 2'b00, 2'b00, 1'b0);
    ext_irq_i = 4'b1010; #1;
    check("R11 external all", {4'h0, irq_o}, {4'h0, 4'b1010});

    // R1 reset mid-run
    rst_n = 1'b0; @(posedge clk); @(negedge clk);
    check("R1 status after reset", status_o, 8'h00);
    read_reg(ACT, v); check("R1 routing after reset", v, 8'h00);
    check("R1 irq after reset", {4'h0, irq_o}, {4'h0, 4'b1010});
    rst_n = 1'b1; ext_irq_i = 4'b0000; @(negedge clk);

    cycle(WR, ACT, 8'h0F, 2'b00, 2'b00, 1'b0);
    check("R11 timer idle", {4'h0, irq_o}, 8'h00);
    cycle(IDL, 8'h00, 8'h00, 2'b00, 2'b10, 1'b0);
    check("R11 compare-2 only", {4'h0, irq_o}, {4'h0, 4'b0101});
    cycle(IDL, 8'h00, 8'h00, 2'b00, 2'b00, 1'b1);
    check("R11 plus overflow", {4'h0, irq_o}, {4'h0, 4'b1101});
    cycle(WR, ACT, 8'h02, 2'b00, 2'b00, 1'b0);
    check("R11 capture only selected", {4'h0, irq_o}, 8'h00);
    ext_irq_i = 4'b1111; #1;
    check("R11 mixed select", {4'h0, irq_o}, {4'h0, want_irq(8'h28, 4'b0010, 4'b1111)});

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule